// File: doc/BRIEF.md
# Byte and Bit Reversal Unit

This block reorders a 32-bit operand in one of four ways, chosen by a 2-bit operation code. It can reverse all four bytes, swap the two bytes inside each halfword, swap the bytes of the low halfword and sign-extend the result, or mirror all 32 bits. It sits in an execute stage. A decoder supplies the operand, the operation code, the destination and source register indices, and a condition-pass bit. The unit returns the result one clock later, together with a write strobe for the register file.

The outcome of each accepted operation is held in a registered state: empty, write, skip or fault. Transitions happen on every clock edge. With no valid input the state goes to EMPTY. A valid input that names index 13 or 15 as destination or source goes to FAULT. A valid input whose condition failed goes to SKIP. Any other valid input goes to WRITE. The unit has no flag outputs, so no operation can change the status flags.

Top module: `byte_bit_reorder`

## Requirements
- R1: With operation code 2'b00, the result is the operand with its byte order reversed: operand byte k (bits 8k+7:8k) appears as result byte 3-k.
- R2: With operation code 2'b01, the two bytes within each 16-bit halfword are exchanged. Each halfword stays in its own position.
- R3: With operation code 2'b10, the bytes of operand bits [15:0] are exchanged to give result bits [15:0]. Bits [31:16] are filled with copies of the original operand bit 7.
- R4: With operation code 2'b11, operand bit i appears at result bit 31-i for every i.
- R5: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R6: `out_wr_en` is high in the cycle after a valid input only if that input had `in_cond_pass` high and used no illegal index. It is never high without `out_valid`.
- R7: A valid input whose destination or source index equals 13 or 15 raises `out_illegal` in the following cycle and keeps `out_wr_en` low, whatever the condition bit.
- R8: Synchronous active-high reset clears `out_valid`, `out_wr_en` and `out_illegal`.
- R9: In a cycle after a cycle with `in_valid` low, `out_result` and `out_dst_idx` keep their previous values.
- R10: `out_dst_idx` carries the destination index of the input that produced the current result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 2 | Operation code (00 byte reverse, 01 halfword byte swap, 10 signed low swap, 11 bit mirror) |
| in_operand | input | 32 | Source value |
| in_dst_idx | input | 4 | Destination register index |
| in_src_idx | input | 4 | Source register index |
| in_cond_pass | input | 1 | Condition evaluated true |
| out_valid | output | 1 | Result slot occupied |
| out_wr_en | output | 1 | Write-back strobe |
| out_illegal | output | 1 | Illegal register index seen |
| out_result | output | 32 | Reordered value |
| out_dst_idx | output | 4 | Destination index for the result |

## Verification
Every result, strobe, fault flag and destination index is due exactly one rising edge after the input cycle that produced it, and each of them depends only on that single input. The bench drives inputs on the falling edge. It samples all outputs one time unit after the next rising edge and compares them with a model updated for that same input. A cycle with no valid input is checked in the same slot: it must show the held result and index and all strobes low.

// File: rtl/reorder_pkg.sv
package reorder_pkg;

    typedef enum logic [1:0] {
        OP_BYTE_REV  = 2'b00,
        OP_HALF_SWAP = 2'b01,
        OP_LOW_SEXT  = 2'b10,
        OP_BIT_REV   = 2'b11
    } reorder_op_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'b00,
        ST_WRITE = 2'b01,
        ST_SKIP  = 2'b10,
        ST_FAULT = 2'b11
    } slot_state_e;

endpackage

// File: rtl/reorder_core.sv
module reorder_core
    import reorder_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result
);
    localparam int N_BYTES  = DATA_W / BYTE_W;
    localparam int HALF_W   = DATA_W / 2;
    localparam int HALF_BYT = HALF_W / BYTE_W;

    logic [DATA_W-1:0] byte_rev;
    logic [DATA_W-1:0] half_swap;
    logic [DATA_W-1:0] low_sext;
    logic [DATA_W-1:0] bit_rev;

    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte_rev
        assign byte_rev[b*BYTE_W +: BYTE_W] = operand[(N_BYTES-1-b)*BYTE_W +: BYTE_W];
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        for (genvar b = 0; b < HALF_BYT; b++) begin : g_byte
            assign half_swap[h*HALF_W + b*BYTE_W +: BYTE_W] =
                operand[h*HALF_W + (HALF_BYT-1-b)*BYTE_W +: BYTE_W];
        end
    end

    assign low_sext = {{HALF_W{half_swap[HALF_W-1]}}, half_swap[HALF_W-1:0]};

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit_rev
        assign bit_rev[i] = operand[DATA_W-1-i];
    end

    always_comb begin
        unique case (reorder_op_e'(op))
            OP_BYTE_REV:  result = byte_rev;
            OP_HALF_SWAP: result = half_swap;
            OP_LOW_SEXT:  result = low_sext;
            OP_BIT_REV:   result = bit_rev;
            default:      result = byte_rev;
        endcase
    end

endmodule

// File: rtl/index_guard.sv
module index_guard #(
    parameter int IDX_W  = 4,
    parameter int SP_IDX = 13,
    parameter int PC_IDX = 15
) (
    input  logic [IDX_W-1:0] dst_idx,
    input  logic [IDX_W-1:0] src_idx,
    output logic             illegal
);
    localparam logic [IDX_W-1:0] SP_CODE = IDX_W'(SP_IDX);
    localparam logic [IDX_W-1:0] PC_CODE = IDX_W'(PC_IDX);

    logic dst_bad;
    logic src_bad;

    assign dst_bad = (dst_idx == SP_CODE) || (dst_idx == PC_CODE);
    assign src_bad = (src_idx == SP_CODE) || (src_idx == PC_CODE);
    assign illegal = dst_bad || src_bad;

endmodule

// File: rtl/byte_bit_reorder.sv
module byte_bit_reorder
    import reorder_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int SP_IDX = 13,
    parameter int PC_IDX = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic [DATA_W-1:0] in_operand,
    input  logic [IDX_W-1:0]  in_dst_idx,
    input  logic [IDX_W-1:0]  in_src_idx,
    input  logic              in_cond_pass,
    output logic              out_valid,
    output logic              out_wr_en,
    output logic              out_illegal,
    output logic [DATA_W-1:0] out_result,
    output logic [IDX_W-1:0]  out_dst_idx
);
    slot_state_e       state_q;
    slot_state_e       state_d;
    logic [DATA_W-1:0] reordered;
    logic              bad_index;
    logic [DATA_W-1:0] result_q;
    logic [IDX_W-1:0]  dst_q;

    reorder_core #(
        .DATA_W (DATA_W),
        .BYTE_W (8)
    ) u_core (
        .op      (in_op),
        .operand (in_operand),
        .result  (reordered)
    );

    index_guard #(
        .IDX_W  (IDX_W),
        .SP_IDX (SP_IDX),
        .PC_IDX (PC_IDX)
    ) u_guard (
        .dst_idx (in_dst_idx),
        .src_idx (in_src_idx),
        .illegal (bad_index)
    );

    // Next outcome: fault outranks a failed condition, which outranks a write.
    always_comb begin
        if (!in_valid) begin
            state_d = ST_EMPTY;
        end else if (bad_index) begin
            state_d = ST_FAULT;
        end else if (!in_cond_pass) begin
            state_d = ST_SKIP;
        end else begin
            state_d = ST_WRITE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Data path captures only on valid input and otherwise holds.
    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            dst_q    <= '0;
        end else if (in_valid) begin
            result_q <= reordered;
            dst_q    <= in_dst_idx;
        end
    end

    always_comb begin
        out_valid   = 1'b0;
        out_wr_en   = 1'b0;
        out_illegal = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
            end
            ST_WRITE: begin
                out_valid = 1'b1;
                out_wr_en = 1'b1;
            end
            ST_SKIP: begin
                out_valid = 1'b1;
            end
            ST_FAULT: begin
                out_valid   = 1'b1;
                out_illegal = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign out_result  = result_q;
    assign out_dst_idx = dst_q;

endmodule

// File: rtl/reorder_unit_checker.sv
module reorder_unit_checker #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [IDX_W-1:0]  in_dst_idx,
    input logic [IDX_W-1:0]  in_src_idx,
    input logic              in_cond_pass,
    input logic              out_valid,
    input logic              out_wr_en,
    input logic              out_illegal,
    input logic [DATA_W-1:0] out_result,
    input logic [IDX_W-1:0]  out_dst_idx
);
    logic bad_in;
    assign bad_in = (in_dst_idx == IDX_W'(13)) || (in_dst_idx == IDX_W'(15)) ||
                    (in_src_idx == IDX_W'(13)) || (in_src_idx == IDX_W'(15));

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R5
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R5
    AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) out_wr_en |-> out_valid); // R6
    AST_WR_NEEDS_PASS: assert property (@(posedge clk) disable iff (rst) (in_valid && !in_cond_pass) |=> !out_wr_en); // R6
    AST_FAULT_RAISED: assert property (@(posedge clk) disable iff (rst) (in_valid && bad_in) |=> (out_illegal && !out_wr_en)); // R7
    AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) $onehot0({out_wr_en, out_illegal})); // R7
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(out_result) && $stable(out_dst_idx))); // R9

endmodule

bind byte_bit_reorder reorder_unit_checker #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) u_checker (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_dst_idx   (in_dst_idx),
    .in_src_idx   (in_src_idx),
    .in_cond_pass (in_cond_pass),
    .out_valid    (out_valid),
    .out_wr_en    (out_wr_en),
    .out_illegal  (out_illegal),
    .out_result   (out_result),
    .out_dst_idx  (out_dst_idx)
);

// File: tb/byte_bit_reorder_test.sv
module byte_bit_reorder_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_op;
    logic [31:0] in_operand;
    logic [3:0]  in_dst_idx;
    logic [3:0]  in_src_idx;
    logic        in_cond_pass;
    logic        out_valid;
    logic        out_wr_en;
    logic        out_illegal;
    logic [31:0] out_result;
    logic [3:0]  out_dst_idx;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [31:0] model_result;
    logic [3:0]  model_dst;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_bit_reorder uut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_op        (in_op),
        .in_operand   (in_operand),
        .in_dst_idx   (in_dst_idx),
        .in_src_idx   (in_src_idx),
        .in_cond_pass (in_cond_pass),
        .out_valid    (out_valid),
        .out_wr_en    (out_wr_en),
        .out_illegal  (out_illegal),
        .out_result   (out_result),
        .out_dst_idx  (out_dst_idx)
    );

    function automatic logic [31:0] expect_value(input logic [1:0] op, input logic [31:0] d);
        logic [31:0] r;
        case (op)
            2'b00: r = {d[7:0], d[15:8], d[23:16], d[31:24]};
            2'b01: r = {d[23:16], d[31:24], d[7:0], d[15:8]};
            2'b10: r = {{16{d[7]}}, d[7:0], d[15:8]};
            default: begin
                for (int i = 0; i < 32; i++) r[i] = d[31-i];
            end
        endcase
        return r;
    endfunction

    function automatic bit is_bad(input logic [3:0] idx);
        return (idx == 4'd13) || (idx == 4'd15);
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Apply one input cycle and check the outputs one edge later.
    task automatic step(input bit v, input logic [1:0] op, input logic [31:0] d,
                        input logic [3:0] dst, input logic [3:0] src, input bit cond);
        bit bad;
        @(negedge clk);
        in_valid = v; in_op = op; in_operand = d;
        in_dst_idx = dst; in_src_idx = src; in_cond_pass = cond;
        bad = is_bad(dst) || is_bad(src);
        if (v) begin
            model_result = expect_value(op, d);
            model_dst    = dst;
        end
        @(posedge clk);
        #1;
        check("R5", "out_valid", 32'(out_valid), 32'(v));
        check("R6", "out_wr_en", 32'(out_wr_en), 32'(v && cond && !bad));
        check("R7", "out_illegal", 32'(out_illegal), 32'(v && bad));
        case (op)
            2'b00: check(v ? "R1" : "R9", "out_result", out_result, model_result);
            2'b01: check(v ? "R2" : "R9", "out_result", out_result, model_result);
            2'b10: check(v ? "R3" : "R9", "out_result", out_result, model_result);
            default: check(v ? "R4" : "R9", "out_result", out_result, model_result);
        endcase
        check(v ? "R10" : "R9", "out_dst_idx", 32'(out_dst_idx), 32'(model_dst));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        in_valid = 0; in_op = 0; in_operand = 0;
        in_dst_idx = 0; in_src_idx = 0; in_cond_pass = 0;
        model_result = '0; model_dst = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R8", "out_valid", 32'(out_valid), 0);
        check("R8", "out_wr_en", 32'(out_wr_en), 0);
        check("R8", "out_illegal", 32'(out_illegal), 0);
        @(negedge clk);
        rst = 1'b0;

        // Directed cases per mode.
        step(1, 2'b00, 32'h12345678, 4'd3, 4'd7, 1);   // R1 -> 78563412
        step(1, 2'b01, 32'h12345678, 4'd0, 4'd0, 1);   // R2 -> 34127856
        step(1, 2'b10, 32'h000000F0, 4'd4, 4'd5, 1);   // R3 -> FFFFF000
        step(1, 2'b10, 32'h1234FF7F, 4'd4, 4'd5, 1);   // R3 -> 00007FFF
        step(1, 2'b11, 32'h00000001, 4'd7, 4'd8, 1);   // R4 -> 80000000
        step(1, 2'b11, 32'hF0000000, 4'd7, 4'd8, 1);   // R4 -> 0000000F
        step(0, 2'b00, 32'hDEADBEEF, 4'd9, 4'd1, 1);   // R9 hold
        step(1, 2'b00, 32'hCAFEF00D, 4'd2, 4'd2, 0);   // R6 condition fail
        step(1, 2'b01, 32'hAABBCCDD, 4'd13, 4'd1, 1);  // R7 destination SP
        step(1, 2'b01, 32'hAABBCCDD, 4'd1, 4'd15, 0);  // R7 source PC, cond fail
        step(1, 2'b11, 32'h13572468, 4'd15, 4'd13, 1); // R7 both
        step(0, 2'b11, 32'h0, 4'd0, 4'd0, 0);          // R9 hold after fault

        // Reset mid-stream clears the strobes (R8).
        step(1, 2'b00, 32'h01020304, 4'd6, 4'd6, 1);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(posedge clk);
        #1;
        check("R8", "out_valid after reset", 32'(out_valid), 0);
        check("R8", "out_wr_en after reset", 32'(out_wr_en), 0);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        model_result = '0; model_dst = '0;
        step(0, 2'b00, 32'h0, 4'd0, 4'd0, 0);

        // Constrained random: valid about 3/4 of cycles.
        for (int n = 0; n < 400; n++) begin
            step(($urandom % 4) != 0, 2'($urandom), $urandom,
                 4'($urandom), 4'($urandom), ($urandom % 5) != 0);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule